// File: doc/BRIEF.md
# ADC Conversion Control and Sequencing Unit

This block is the digital side of an on-chip analog-to-digital converter. Software reaches it through one byte-wide control register on a small address/data port. A write to that register chooses the input channel, the run mode, the low bit of the reference code and the external reference buffer, and a 1 in the top bit starts a conversion. From there a cycle counter times the conversion. When the count ends, the block pulses a sample strobe towards the analog macro, captures the converter's result word and raises a one-cycle done pulse.

There are two run modes. In single-shot mode one conversion lasts 5129 clock cycles and then the busy bit falls by itself. In continuous mode a fresh result lands every 256 cycles until software clears the continuous bit. The 2-bit reference code is formed from an outside high bit and the register's low bit, then decoded for the analog side. The analog converter, the reference buffers and the pin muxing are outside the block and appear only as plain ports.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset every control bit is 0. A read of address 0xF70 returns the register on `rdata_o` one cycle after `rd_en` in the layout bit 7 busy/start, bit 6 reference low bit, bit 5 external buffer, bit 4 continuous, bits 3:0 channel.
- R2: A write to 0xF70 stores bits 6:0 of `wdata`, and they read back unchanged.
- R3: A write to 0xF70 with bit 7 set starts a conversion, and bit 7 reads as 1 while the conversion runs.
- R4: A write with bit 7 clear neither starts, stops nor restarts a conversion.
- R5: In single-shot mode the done pulse appears exactly 5129 cycles after the starting write edge, and bit 7 then reads 0.
- R6: In continuous mode a done pulse appears every 256 cycles and bit 7 stays 1.
- R7: At each completion `sample_strobe_o` and `conv_done_o` are high for one cycle, and `result_o` takes the value `adc_data_i` had at the completion edge.
- R8: A start written during a conversion drops it and begins timing again from that write. No completion occurs at the old point.
- R9: The channel and the mode are captured at start. Later writes without bit 7 change neither `chan_sel_o` nor the period of the running conversion.
- R10: Clearing the continuous bit during continuous running lets the current 256-cycle period finish and latch its result, and then bit 7 clears with no further done pulses.
- R11: `ref_code_o` is {`ref_hi_i`, register bit 6}, with 00 = external pin, 01 = 1.0 V, 10 = 2.0 V and 11 = reserved. `int_ref_en_o` is 1 for any nonzero code, and `ref_rsvd_o` is 1 only for code 11. The code is passed on unchanged.
- R12: `ref_buf_en_o` follows register bit 5.
- R13: Writes to any other address are ignored, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register address |
| wdata | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| ref_hi_i | input | 1 | High reference-code bit from the companion register |
| adc_data_i | input | 10 | Result word from the analog converter |
| chan_sel_o | output | 4 | Channel select to the analog multiplexer |
| sample_strobe_o | output | 1 | One-cycle sample strobe at completion |
| conv_done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 10 | Latched conversion result |
| ref_code_o | output | 2 | Reference level code to the analog side |
| int_ref_en_o | output | 1 | Internal reference enabled |
| ref_rsvd_o | output | 1 | Reserved reference code present |
| ref_buf_en_o | output | 1 | Drive the internal reference onto the reference pin |

## Verification
A table of register writes paired with the reference-high input walks all four reference codes with both states of the buffer bit. This separates the code pass-through, the internal-enable decode and the reserved flag from each other and from the read-back path. The sequencer runs a clean single-shot, a single-shot with a mid-run write that has bit 7 clear, a two-period continuous run stopped by clearing the continuous bit, and a restart written over a running conversion. Measuring the cycle of each done pulse from its start write shows whether the right period was used, whether the mode and channel were captured at start, and whether a restart truly resets the count. A write to a neighbouring address confirms that the decode is exact.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W = 4;

  // Bit layout of the control byte; software depends on these positions.
  typedef struct packed {
    logic            conv_on;
    logic            ref_lo;
    logic            ext_ref;
    logic            cont;
    logic [CH_W-1:0] chan;
  } ctrl_byte_t;

  typedef enum logic [1:0] {
    REF_EXT_PIN = 2'b00,
    REF_1V0     = 2'b01,
    REF_2V0     = 2'b10,
    REF_RSVD    = 2'b11
  } ref_code_e;
endpackage

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
  import adc_seq_pkg::*;
#(
  parameter int                 ADDR_W    = 12,
  parameter logic [ADDR_W-1:0]  CTRL_ADDR = 12'hF70
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]      wdata,
  input  logic            busy_i,
  output logic            ref_lo_o,
  output logic            ext_ref_o,
  output logic            cont_o,
  output logic            start_o,
  output logic [CH_W-1:0] start_chan_o,
  output logic            start_cont_o,
  output logic [7:0]      rdata_o
);
  ctrl_byte_t wr_byte, rd_view;
  logic       wr_hit, rd_hit;
  logic            ref_lo_q, ext_q, cont_q;
  logic [CH_W-1:0] chan_q;

  assign wr_byte = ctrl_byte_t'(wdata);
  assign wr_hit  = wr_en && (addr == CTRL_ADDR);
  assign rd_hit  = rd_en && (addr == CTRL_ADDR);

  assign start_o      = wr_hit && wr_byte.conv_on;
  assign start_chan_o = wr_byte.chan;
  assign start_cont_o = wr_byte.cont;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_lo_q <= 1'b0;
      ext_q    <= 1'b0;
      cont_q   <= 1'b0;
      chan_q   <= '0;
    end else if (wr_hit) begin
      ref_lo_q <= wr_byte.ref_lo;
      ext_q    <= wr_byte.ext_ref;
      cont_q   <= wr_byte.cont;
      chan_q   <= wr_byte.chan;
    end
  end

  always_comb begin
    rd_view.conv_on = busy_i;
    rd_view.ref_lo  = ref_lo_q;
    rd_view.ext_ref = ext_q;
    rd_view.cont    = cont_q;
    rd_view.chan    = chan_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_o <= '0;
    else if (rd_hit) rdata_o <= rd_view;
    else             rdata_o <= '0;
  end

  assign ref_lo_o  = ref_lo_q;
  assign ext_ref_o = ext_q;
  assign cont_o    = cont_q;
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int SINGLE_CYCLES = 5129,
  parameter int CONT_CYCLES   = 256,
  parameter int CH_W          = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [CH_W-1:0] start_chan_i,
  input  logic            start_cont_i,
  input  logic            cont_live_i,
  output logic            busy_o,
  output logic            complete_o,
  output logic [CH_W-1:0] chan_sel_o,
  output logic            done_o,
  output logic            strobe_o
);
  localparam int MAX_CYC = (SINGLE_CYCLES > CONT_CYCLES) ? SINGLE_CYCLES : CONT_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SINGLE_LAST = CNT_W'(SINGLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] CONT_LAST   = CNT_W'(CONT_CYCLES - 1);

  logic             busy_q, cont_run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt   = cont_run_q ? CONT_LAST : SINGLE_LAST;
  // A start on the same edge wins over a completion.
  assign complete_o = busy_q && !start_i && (cnt_q == last_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      cont_run_q <= 1'b0;
      cnt_q      <= '0;
      chan_sel_o <= '0;
      done_o     <= 1'b0;
      strobe_o   <= 1'b0;
    end else begin
      done_o   <= complete_o;
      strobe_o <= complete_o;
      if (start_i) begin
        busy_q     <= 1'b1;
        cnt_q      <= '0;
        chan_sel_o <= start_chan_i;
        cont_run_q <= start_cont_i;
      end else if (complete_o) begin
        cnt_q <= '0;
        if (!cont_run_q || !cont_live_i) busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/adc_ref_decode.sv
module adc_ref_decode
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_hi_i,
  input  logic       ref_lo_i,
  input  logic       ext_ref_i,
  output logic [1:0] ref_code_o,
  output logic       int_ref_en_o,
  output logic       rsvd_o,
  output logic       buf_en_o
);
  ref_code_e code;
  assign code = ref_code_e'({ref_hi_i, ref_lo_i});

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_code_o   <= '0;
      int_ref_en_o <= 1'b0;
      rsvd_o       <= 1'b0;
      buf_en_o     <= 1'b0;
    end else begin
      ref_code_o   <= code;
      int_ref_en_o <= (code != REF_EXT_PIN);
      rsvd_o       <= (code == REF_RSVD);
      buf_en_o     <= ext_ref_i;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int                ADDR_W        = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR     = 12'hF70,
  parameter int                RES_W         = 10,
  parameter int                SINGLE_CYCLES = 5129,
  parameter int                CONT_CYCLES   = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata_o,
  input  logic              ref_hi_i,
  input  logic [RES_W-1:0]  adc_data_i,
  output logic [CH_W-1:0]   chan_sel_o,
  output logic              sample_strobe_o,
  output logic              conv_done_o,
  output logic [RES_W-1:0]  result_o,
  output logic [1:0]        ref_code_o,
  output logic              int_ref_en_o,
  output logic              ref_rsvd_o,
  output logic              ref_buf_en_o
);
  logic            busy, complete;
  logic            ref_lo, ext_ref, cont_live;
  logic            start;
  logic [CH_W-1:0] start_chan;
  logic            start_cont;

  adc_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .busy_i(busy), .ref_lo_o(ref_lo), .ext_ref_o(ext_ref),
    .cont_o(cont_live), .start_o(start), .start_chan_o(start_chan),
    .start_cont_o(start_cont), .rdata_o(rdata_o)
  );

  adc_conv_timer #(
    .SINGLE_CYCLES(SINGLE_CYCLES), .CONT_CYCLES(CONT_CYCLES), .CH_W(CH_W)
  ) u_timer (
    .clk(clk), .rst(rst), .start_i(start), .start_chan_i(start_chan),
    .start_cont_i(start_cont), .cont_live_i(cont_live), .busy_o(busy),
    .complete_o(complete), .chan_sel_o(chan_sel_o), .done_o(conv_done_o),
    .strobe_o(sample_strobe_o)
  );

  adc_ref_decode u_ref (
    .clk(clk), .rst(rst), .ref_hi_i(ref_hi_i), .ref_lo_i(ref_lo),
    .ext_ref_i(ext_ref), .ref_code_o(ref_code_o), .int_ref_en_o(int_ref_en_o),
    .rsvd_o(ref_rsvd_o), .buf_en_o(ref_buf_en_o)
  );

  always_ff @(posedge clk) begin
    if (rst)           result_o <= '0;
    else if (complete) result_o <= adc_data_i;
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'hF70,
  parameter int                RES_W     = 10,
  parameter int                CH_W      = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              busy,
  input logic              conv_done_o,
  input logic [RES_W-1:0]  adc_data_i,
  input logic [RES_W-1:0]  result_o,
  input logic [1:0]        ref_code_o,
  input logic              ref_rsvd_o,
  input logic              ref_buf_en_o,
  input logic [CH_W-1:0]   chan_sel_o
);
  logic hit;
  assign hit = wr_en && (addr == CTRL_ADDR);

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (hit && wdata[7]) |=> busy);

  assert_zero_write_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (hit && !wdata[7] && !busy) |=> !busy);

  assert_done_single_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    conv_done_o |=> !conv_done_o);

  assert_result_capture_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_done_o) |-> (result_o == $past(adc_data_i)));

  assert_chan_held_R9: assert property (@(posedge clk) disable iff (rst)
    !(hit && wdata[7]) |=> $stable(chan_sel_o));

  assert_rsvd_flag_R11: assert property (@(posedge clk) disable iff (rst)
    ref_rsvd_o == (ref_code_o == 2'b11));

  assert_buf_follow_R12: assert property (@(posedge clk) disable iff (rst)
    hit |=> ##1 (ref_buf_en_o == $past(wdata[5], 2)));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .RES_W(RES_W), .CH_W(adc_seq_pkg::CH_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .busy(busy), .conv_done_o(conv_done_o), .adc_data_i(adc_data_i),
  .result_o(result_o), .ref_code_o(ref_code_o), .ref_rsvd_o(ref_rsvd_o),
  .ref_buf_en_o(ref_buf_en_o), .chan_sel_o(chan_sel_o)
);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/100ps
module adc_seq_ctrl_bench;
  localparam int SINGLE = 5129;
  localparam int CONT   = 256;
  localparam logic [11:0] CADDR = 12'hF70;

  logic        clk = 1'b0, rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata_o;
  logic        ref_hi_i = 1'b0;
  logic [9:0]  adc_data_i = '0;
  logic [3:0]  chan_sel_o;
  logic        sample_strobe_o, conv_done_o;
  logic [9:0]  result_o;
  logic [1:0]  ref_code_o;
  logic        int_ref_en_o, ref_rsvd_o, ref_buf_en_o;

  int checks = 0, failures = 0, cyc_cnt = 0, done_count = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;
  always @(negedge clk) if (conv_done_o) done_count <= done_count + 1;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata_o(rdata_o), .ref_hi_i(ref_hi_i),
    .adc_data_i(adc_data_i), .chan_sel_o(chan_sel_o),
    .sample_strobe_o(sample_strobe_o), .conv_done_o(conv_done_o),
    .result_o(result_o), .ref_code_o(ref_code_o), .int_ref_en_o(int_ref_en_o),
    .ref_rsvd_o(ref_rsvd_o), .ref_buf_en_o(ref_buf_en_o)
  );

  // {wdata[7:0], ref_hi, code[1:0], int_en, rsvd, buf_en}
  localparam int NV = 6;
  localparam logic [13:0] VEC [NV] = '{
    {8'h00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0},
    {8'h40, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0},
    {8'h20, 1'b1, 2'b10, 1'b1, 1'b0, 1'b1},
    {8'h60, 1'b1, 2'b11, 1'b1, 1'b1, 1'b1},
    {8'h2A, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1},
    {8'h5F, 1'b1, 2'b11, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata_o;
    rd_en = 1'b0; addr = '0;
  endtask

  task automatic wait_done(input int from, input int limit, output int el);
    el = -1;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (conv_done_o) begin
        el = cyc_cnt - from;
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int from, el, dcyc, dc0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    reg_read(CADDR, rd);
    check(rd == 8'h00, "R1 reset read", rd, 0);
    check(conv_done_o == 1'b0 && sample_strobe_o == 1'b0, "R1 reset pulses", conv_done_o, 0);
    check(chan_sel_o == 4'h0 && result_o == 10'h0, "R1 reset chan/result", result_o, 0);
    check(ref_code_o == 2'b00 && ref_buf_en_o == 1'b0, "R1 reset ref", ref_code_o, 0);

    // R11 R12 R2: table walk of reference decode and read-back
    for (int i = 0; i < NV; i++) begin
      ref_hi_i = VEC[i][5];
      reg_write(CADDR, VEC[i][13:6]);
      @(negedge clk);
      check(ref_code_o == VEC[i][4:3], "R11 ref code", ref_code_o, VEC[i][4:3]);
      check(int_ref_en_o == VEC[i][2], "R11 int enable", int_ref_en_o, VEC[i][2]);
      check(ref_rsvd_o == VEC[i][1], "R11 reserved flag", ref_rsvd_o, VEC[i][1]);
      check(ref_buf_en_o == VEC[i][0], "R12 buffer enable", ref_buf_en_o, VEC[i][0]);
      reg_read(CADDR, rd);
      check(rd == VEC[i][13:6], "R2 read back", rd, VEC[i][13:6]);
    end
    ref_hi_i = 1'b0;

    // R13: other address ignored, reads zero
    reg_write(12'hF71, 8'hFF);
    reg_read(CADDR, rd);
    check(rd == 8'h5F, "R13 foreign write ignored", rd, 8'h5F);
    reg_read(12'hF71, rd);
    check(rd == 8'h00, "R13 foreign read zero", rd, 0);
    check(conv_done_o == 1'b0, "R13 no start", conv_done_o, 0);

    // R5 R3 R7: clean single shot on channel 7
    adc_data_i = 10'h2C5;
    reg_write(CADDR, 8'h87);
    from = cyc_cnt;
    reg_read(CADDR, rd);
    check(rd[7] == 1'b1, "R3 busy reads 1", rd, 8'h87);
    check(chan_sel_o == 4'h7, "R3 channel driven", chan_sel_o, 7);
    wait_done(from, SINGLE + 10, el);
    check(el == SINGLE, "R5 single-shot period", el, SINGLE);
    check(sample_strobe_o == 1'b1, "R7 strobe at completion", sample_strobe_o, 1);
    check(result_o == 10'h2C5, "R7 result latched", result_o, 10'h2C5);
    @(negedge clk);
    check(conv_done_o == 1'b0 && sample_strobe_o == 1'b0, "R7 one-cycle pulses", conv_done_o, 0);
    reg_read(CADDR, rd);
    check(rd[7] == 1'b0, "R5 busy self-clears", rd[7], 0);

    // R9 R4: single shot on ch 2, mid-run write with bit7 clear sets cont and ch 5
    adc_data_i = 10'h111;
    reg_write(CADDR, 8'h82);
    from = cyc_cnt;
    repeat (50) @(negedge clk);
    reg_write(CADDR, 8'h15);
    check(chan_sel_o == 4'h2, "R9 channel held", chan_sel_o, 2);
    wait_done(from, SINGLE + 10, el);
    check(el == SINGLE, "R4 R9 period unchanged by write", el, SINGLE);
    check(result_o == 10'h111, "R7 result second", result_o, 10'h111);
    reg_read(CADDR, rd);
    check(rd == 8'h15, "R9 single ends, fields stored", rd, 8'h15);

    // R6: continuous on channel 3
    adc_data_i = 10'h155;
    reg_write(CADDR, 8'h93);
    from = cyc_cnt;
    wait_done(from, CONT + 10, el);
    check(el == CONT, "R6 first continuous period", el, CONT);
    check(result_o == 10'h155, "R6 first result", result_o, 10'h155);
    check(chan_sel_o == 4'h3, "R6 channel", chan_sel_o, 3);
    adc_data_i = 10'h0AA;
    from = cyc_cnt;
    wait_done(from, CONT + 10, el);
    dcyc = cyc_cnt;
    check(el == CONT, "R6 second continuous period", el, CONT);
    check(result_o == 10'h0AA, "R6 second result", result_o, 10'h0AA);
    reg_read(CADDR, rd);
    check(rd[7] == 1'b1, "R6 busy stays set", rd[7], 1);

    // R10: clear continuous bit mid-period
    repeat (100) @(negedge clk);
    adc_data_i = 10'h3E1;
    reg_write(CADDR, 8'h03);
    wait_done(dcyc, CONT + 10, el);
    check(el == CONT, "R10 current period finishes", el, CONT);
    check(result_o == 10'h3E1, "R10 last result", result_o, 10'h3E1);
    reg_read(CADDR, rd);
    check(rd == 8'h03, "R10 busy cleared", rd, 8'h03);
    dc0 = done_count;
    repeat (300) @(negedge clk);
    check(done_count == dc0, "R10 no further completions", done_count, dc0);

    // R8: restart during single shot
    reg_write(CADDR, 8'h80);
    repeat (1000) @(negedge clk);
    reg_write(CADDR, 8'h80);
    from = cyc_cnt;
    wait_done(from, SINGLE + 10, el);
    check(el == SINGLE, "R8 restart resets timing", el, SINGLE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule